// File: doc/BRIEF.md
# Byte Add/Subtract Unit with Status Flags

This block is a small integer arithmetic unit for a byte-wide datapath. It accepts a destination operand and a source operand, one of four arithmetic opcodes, and the carry flag as currently held by the surrounding processor. It returns a registered result together with a registered set of four status flags: carry, overflow, sign and zero.

Subtraction is performed by feeding the inverted source operand into the same adder that serves addition, with an adjusted carry-in. On the subtract forms the stored carry output is the complement of the adder's end carry, so it reads as an unsigned borrow. The plain forms ignore the incoming carry. The chained forms consume it, which lets wider values be processed one byte at a time, with each byte's carry or borrow feeding the next.

A valid strobe qualifies each operation. The result and flag registers change only on a clock edge where the strobe is high.

Top module: `byte_alu`

## Requirements
- R1: Opcode 00 (plain add) loads A + B modulo 256 as the result and the adder's end carry as the carry flag. The carry input has no effect.
- R2: Opcode 01 (chained add) loads A + B + carry_in modulo 256 as the result. The carry flag is set when A + B + carry_in exceeds 255.
- R3: Opcode 10 (plain subtract) loads A − B modulo 256 as the result. The carry flag is set exactly when A < B as unsigned values. The carry input has no effect.
- R4: Opcode 11 (chained subtract) loads A − B − carry_in modulo 256 as the result. The carry flag is set exactly when A < B + carry_in as unsigned values.
- R5: The overflow flag is set when the exact signed result of the operation, including any carry or borrow input that is consumed, lies outside −128..127.
- R6: The sign flag equals bit 7 of the loaded result.
- R7: The zero flag is set exactly when the loaded 8-bit result is zero, whatever the earlier bytes of a chained sequence held.
- R8: On a rising clock edge with op_valid low, the result and all four flags keep their previous values.
- R9: While rst_n is low, the result and all four flags are zero.
- R10: With op_valid high, the result and flags of an operation appear one clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Loads result and flags at the next edge |
| op_code | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| opnd_a | input | 8 | Destination operand (minuend / augend) |
| opnd_b | input | 8 | Source operand (subtrahend / addend) |
| carry_in | input | 1 | Stored carry flag supplied by the surrounding logic |
| res_q | output | 8 | Registered result |
| carry_q | output | 1 | Carry flag: end carry on add, borrow on subtract |
| ovf_q | output | 1 | Signed overflow flag |
| sign_q | output | 1 | Sign flag |
| zero_q | output | 1 | Zero flag |

## Verification
The bench targets the borrow polarity. A design that passes the raw end carry through on subtraction would report 80h − 90h without a borrow and 05h − 05h with one. It drives a set carry input into the plain forms, which catches a design that lets the stored carry leak into add or subtract. It also drives a chained subtract of 00h − 00h with borrow in, which must give FFh with the borrow still set. The bench probes signed overflow at 7Fh + 01h and 80h − 01h, where a wrong operand-sign test flips the overflow flag. It also checks idle cycles, during which a register enabled without regard to op_valid would change the held values.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_ADC = 2'b01,
      OP_SUB = 2'b10,
      OP_SBB = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic carry;
      logic ovf;
      logic sign;
      logic zero;
   } alu_flags_t;

   localparam int ADDER_RIPPLE     = 0;
   localparam int ADDER_BEHAVIORAL = 1;

   function automatic logic op_is_sub(alu_op_e op);
      return op[1];
   endfunction

   function automatic logic op_is_chained(alu_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/byte_alu_operand.sv
module byte_alu_operand
   import byte_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] b_in,
   input  logic             carry_in,
   output logic [WIDTH-1:0] b_eff,
   output logic             adder_cin
);

   logic use_carry;

   initial begin
      assert (WIDTH >= 2) else $error("byte_alu_operand: WIDTH must be at least 2");
   end

   assign use_carry = op_is_chained(op) & carry_in;

   // Subtract: A + ~B + 1 - borrow == A + ~B + ~borrow
   always_comb begin
      if (op_is_sub(op)) begin
         b_eff     = ~b_in;
         adder_cin = ~use_carry;
      end else begin
         b_eff     = b_in;
         adder_cin = use_carry;
      end
   end

endmodule

// File: rtl/byte_alu_adder.sv
module byte_alu_adder
   import byte_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int STYLE = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             msb_cin
);

   initial begin
      assert (STYLE == ADDER_RIPPLE || STYLE == ADDER_BEHAVIORAL)
         else $error("byte_alu_adder: unknown STYLE %0d", STYLE);
   end

   generate
      if (STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic p, g;
            assign p        = a[i] ^ b[i];
            assign g        = a[i] & b[i];
            assign sum[i]   = p ^ c[i];
            assign c[i+1]   = g | (p & c[i]);
         end
         assign cout    = c[WIDTH];
         assign msb_cin = c[WIDTH-1];
      end else begin : g_behav
         logic [WIDTH:0]   full;
         logic [WIDTH-1:0] low;
         assign full    = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
         assign sum     = full[WIDTH-1:0];
         assign cout    = full[WIDTH];
         assign low     = {1'b0, a[WIDTH-2:0]} + {1'b0, b[WIDTH-2:0]} + {{(WIDTH-1){1'b0}}, cin};
         assign msb_cin = low[WIDTH-1];
      end
   endgenerate

endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
   import byte_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b_raw,
   input  logic             carry_in,
   input  logic [WIDTH-1:0] sum,
   input  logic             cout,
   input  logic             msb_cin,
   output alu_flags_t       flags
);

   always_comb begin
      flags.carry = op_is_sub(op) ? ~cout : cout;
      flags.ovf   = cout ^ msb_cin;
      flags.sign  = sum[WIDTH-1];
      flags.zero  = (sum == '0);
   end

   // R3
   sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SUB) |-> (flags.carry == (a < b_raw)));

   // R4
   sbb_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SBB) |-> (flags.carry ==
         ({1'b0, a} < ({1'b0, b_raw} + {{WIDTH{1'b0}}, carry_in}))));

endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_RIPPLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [1:0]       op_code,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] res_q,
   output logic             carry_q,
   output logic             ovf_q,
   output logic             sign_q,
   output logic             zero_q
);

   alu_op_e          op;
   logic [WIDTH-1:0] b_eff;
   logic             adder_cin;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             msb_cin;
   alu_flags_t       flags_nxt;
   alu_flags_t       flags_r;

   assign op = alu_op_e'(op_code);

   byte_alu_operand #(.WIDTH(WIDTH)) u_operand (
      .op        (op),
      .b_in      (opnd_b),
      .carry_in  (carry_in),
      .b_eff     (b_eff),
      .adder_cin (adder_cin)
   );

   byte_alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .a       (opnd_a),
      .b       (b_eff),
      .cin     (adder_cin),
      .sum     (sum),
      .cout    (cout),
      .msb_cin (msb_cin)
   );

   byte_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .a        (opnd_a),
      .b_raw    (opnd_b),
      .carry_in (carry_in),
      .sum      (sum),
      .cout     (cout),
      .msb_cin  (msb_cin),
      .flags    (flags_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_r <= '0;
      end else if (op_valid) begin
         res_q   <= sum;
         flags_r <= flags_nxt;
      end
   end

   assign carry_q = flags_r.carry;
   assign ovf_q   = flags_r.ovf;
   assign sign_q  = flags_r.sign;
   assign zero_q  = flags_r.zero;

   // R1
   adder_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({cout, sum} == ({1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, adder_cin})));

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(res_q) && $stable(flags_r)));

   // R6
   sign_tracks_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (sign_q == res_q[WIDTH-1]));

   // R7
   zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (zero_q == (res_q == '0)));

endmodule

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       op_valid;
   logic [1:0] op_code;
   logic [7:0] opnd_a, opnd_b;
   logic       carry_in;
   logic [7:0] res_q;
   logic       carry_q, ovf_q, sign_q, zero_q;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 0;

   // reference state
   int e_res = 0, e_c = 0, e_v = 0, e_s = 0, e_z = 0;

   always #2 clk = ~clk;

   byte_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .res_q(res_q), .carry_q(carry_q), .ovf_q(ovf_q),
      .sign_q(sign_q), .zero_q(zero_q)
   );

   task automatic check(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(string rq_res, string rq_c);
      check(rq_res, "result", res_q, e_res);
      check(rq_c,   "carry",  carry_q, e_c);
      check(rq_res == "R8" ? "R8" : "R5", "overflow", ovf_q, e_v);
      check(rq_res == "R8" ? "R8" : "R6", "sign", sign_q, e_s);
      check(rq_res == "R8" ? "R8" : "R7", "zero", zero_q, e_z);
   endtask

   // one cycle: drive, clock, update model, compare (R10 latency of one edge)
   task automatic step(bit v, int op, int a, int b, bit ci);
      string rq;
      int full, sa, sb, sfull, cused;
      op_valid = v; op_code = op[1:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; carry_in = ci;
      @(posedge clk);
      #1;
      if (v) begin
         cused = (op == 1 || op == 3) ? int'(ci) : 0;
         sa = (a > 127) ? a - 256 : a;
         sb = (b > 127) ? b - 256 : b;
         if (op < 2) begin
            full  = a + b + cused;
            sfull = sa + sb + cused;
            e_c   = (full > 255) ? 1 : 0;
         end else begin
            full  = a - b - cused;
            sfull = sa - sb - cused;
            e_c   = (full < 0) ? 1 : 0;
         end
         e_res = full & 255;
         e_v   = (sfull > 127 || sfull < -128) ? 1 : 0;
         e_s   = (e_res >> 7) & 1;
         e_z   = (e_res == 0) ? 1 : 0;
         case (op)
            0: rq = "R1";
            1: rq = "R2";
            2: rq = "R3";
            default: rq = "R4";
         endcase
         compare_all(rq, rq);
      end else begin
         compare_all("R8", "R8");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b1; op_code = 2'b00;
      opnd_a = 8'h55; opnd_b = 8'h22; carry_in = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state, even with valid asserted
      check("R9", "result", res_q, 0);
      check("R9", "carry", carry_q, 0);
      check("R9", "overflow", ovf_q, 0);
      check("R9", "sign", sign_q, 0);
      check("R9", "zero", zero_q, 0);
      rst_n = 1'b1;

      // R1 add without carry out; carry input ignored
      step(1, 0, 8'h80, 8'h70, 1);
      // R1 add with end carry
      step(1, 0, 8'h80, 8'h90, 0);
      // R3 subtract with borrow out
      step(1, 2, 8'h80, 8'h90, 0);
      // R3 equal operands, zero result, carry input ignored
      step(1, 2, 8'h05, 8'h05, 1);
      // R4 chained: 0080h - 0090h
      step(1, 2, 8'h80, 8'h90, 0);
      step(1, 3, 8'h00, 8'h00, 1);
      // R2 chained: 0080h + 0090h
      step(1, 0, 8'h80, 8'h90, 0);
      step(1, 1, 8'h00, 8'h00, 1);
      // R2 carry wraps to zero
      step(1, 1, 8'hFF, 8'h00, 1);
      // R5 signed overflow corners
      step(1, 0, 8'h7F, 8'h01, 0);
      step(1, 2, 8'h80, 8'h01, 0);
      step(1, 3, 8'h80, 8'h00, 1);
      step(1, 1, 8'h7F, 8'h00, 1);
      // R8 idle cycles hold values
      step(0, 0, 8'h01, 8'h01, 0);
      step(0, 3, 8'hFF, 8'h00, 1);
      // R7 zero on chained result
      step(1, 3, 8'h01, 8'h00, 1);

      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 5) != 0, $urandom % 4, $urandom % 256,
              $urandom % 256, ($urandom % 2) == 1);
      end

      // R9 reset again clears
      rst_n = 1'b0;
      @(posedge clk); #1;
      check("R9", "result", res_q, 0);
      check("R9", "carry", carry_q, 0);
      e_res = 0; e_c = 0; e_v = 0; e_s = 0; e_z = 0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule